// File: doc/BRIEF.md
# Cycle-Stamped Multi-Port Message Merger

This block gathers outbound messages from several hardware message ports and combines them into one ordered stream for a consumer on the software side. On each port a message moves only when the port's valid and the merger's ready are both high. At that moment the message is stored in a small per-port buffer, together with the current value of a free-running cycle counter. That counter is the global time base: it advances on every clock edge.

The merged output is a valid/ready stream that carries the source port index, the cycle stamp and the payload. The output always presents the buffered head entry with the oldest stamp. When two heads carry the same stamp, the lower port index goes first. The consumer therefore sees messages in global time order, and order within each port is preserved. When a port's buffer is full, that port's ready drops and the sender is held off.

Top module: `stamp_merger`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0 and every bit of `rx_ready` is 1. The stamp counter restarts at zero.
- R2: A message accepted on the k-th rising clock edge after reset release carries stamp k, with the first edge counted as 0. The stamp counter is 32 bits wide.
- R3: A message is accepted on port p only when `tx_valid[p]` and `rx_ready[p]` are both 1 at a clock edge. `rx_ready[p]` is 0 exactly when port p holds DEPTH buffered messages. A slot freed by an output transfer in a cycle becomes usable from the next cycle.
- R4: Messages from one port leave in the order they were accepted. Each keeps its payload, taken from `tx_data[p*DW +: DW]`.
- R5: When buffered head entries have different stamps, the output presents the one with the smallest stamp.
- R6: When several head entries share the smallest stamp, the one with the lowest port index is presented first.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_port`, `out_stamp` and `out_data` hold their values in the next cycle.
- R8: `out_valid` is 1 exactly when at least one message is buffered. A transfer happens when `out_valid` and `out_ready` are both 1 at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controlled clock; each rising edge is one stamp tick |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | NPORTS | Per-port message offered |
| tx_data | input | NPORTS*DW | Per-port payloads, port p in bits p*DW +: DW |
| rx_ready | output | NPORTS | Per-port acceptance; low when that port's buffer is full |
| out_valid | output | 1 | Merged stream entry available |
| out_ready | input | 1 | Consumer takes the entry |
| out_port | output | clog2(NPORTS) | Source port index of the entry |
| out_stamp | output | SW | Cycle stamp of the entry |
| out_data | output | DW | Payload of the entry |

## Verification
The hardest case to reach is every port full at once while equal-stamped heads compete with older heads on higher-indexed ports. In that state, tie-breaking, oldest-first selection and back-pressure all act in the same cycles. The stimulus creates it on purpose. It offers on all ports in the same cycle while the consumer stalls, then drains. It then alternates random phases of heavy offering with a mostly stalled consumer, and light offering with a mostly ready consumer. As a result, buffers fill unevenly, and heads with equal stamps meet heads of different ages.

// File: rtl/stamp_merger.sv
module stamp_merger #(
  parameter int NPORTS = 4,
  parameter int DW = 16,
  parameter int DEPTH = 4,
  parameter int SW = 32,
  localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    tx_valid,
  input  logic [NPORTS*DW-1:0] tx_data,
  output logic [NPORTS-1:0]    rx_ready,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PW-1:0]        out_port,
  output logic [SW-1:0]        out_stamp,
  output logic [DW-1:0]        out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = SW + DW;

  logic [SW-1:0]     stamp_cnt;
  logic [NPORTS-1:0] nonempty;
  logic [EW-1:0]     head [NPORTS];
  logic [PW-1:0]     sel;
  logic [SW-1:0]     best;
  logic              found;

  always_ff @(posedge clk)
    if (!rst_n) stamp_cnt <= '0;
    else        stamp_cnt <= stamp_cnt + 1'b1;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push, pop;

    assign rx_ready[g] = (cnt != CW'(DEPTH));
    assign nonempty[g] = (cnt != '0);
    assign push = tx_valid[g] & rx_ready[g];
    assign pop  = out_valid & out_ready & (sel == PW'(g));
    assign head[g] = mem[rp];

    always_ff @(posedge clk)
      if (push) mem[wp] <= {stamp_cnt, tx_data[g*DW +: DW]};

    always_ff @(posedge clk)
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
      end
  end

  always_comb begin
    sel   = '0;
    best  = '0;
    found = 1'b0;
    for (int p = 0; p < NPORTS; p++)
      if (nonempty[p] && (!found || head[p][EW-1:DW] < best)) begin
        found = 1'b1;
        sel   = PW'(p);
        best  = head[p][EW-1:DW];
      end
  end

  assign out_valid = |nonempty;
  assign out_port  = sel;
  assign out_stamp = head[sel][EW-1:DW];
  assign out_data  = head[sel][DW-1:0];
endmodule

module stamp_merger_chk #(
  parameter int NPORTS = 4,
  parameter int DEPTH = 4,
  parameter int SW = 32,
  parameter int PW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] tx_valid,
  input logic [NPORTS-1:0] rx_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PW-1:0]     out_port,
  input logic [SW-1:0]     out_stamp,
  input logic [SW-1:0]     stamp_cnt
);
  logic [15:0]   occ;
  logic [SW-1:0] last_stamp;
  logic [PW-1:0] last_port;
  logic          seen;

  always_ff @(posedge clk)
    if (!rst_n) begin
      occ  <= '0;
      seen <= 1'b0;
      last_stamp <= '0;
      last_port  <= '0;
    end else begin
      occ <= occ + 16'($countones(tx_valid & rx_ready)) - 16'(out_valid & out_ready);
      if (out_valid && out_ready) begin
        seen <= 1'b1;
        last_stamp <= out_stamp;
        last_port  <= out_port;
      end
    end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 16'(NPORTS * DEPTH));
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == 0) |-> !out_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_port) && $stable(out_stamp)));
  assert_ascend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && seen) |-> (out_stamp >= last_stamp));
  assert_tie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && seen && out_stamp == last_stamp) |-> (out_port > last_port));
  assert_past_stamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_stamp < stamp_cnt));
endmodule

bind stamp_merger stamp_merger_chk #(
  .NPORTS(NPORTS), .DEPTH(DEPTH), .SW(SW), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .rx_ready(rx_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port),
  .out_stamp(out_stamp), .stamp_cnt(stamp_cnt)
);

// File: tb/stamp_merger_bench.sv
module stamp_merger_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int DW = 16;
  localparam int DEPTH = 4;
  localparam int SW = 32;
  localparam int PW = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     tx_valid = '0;
  logic [NP*DW-1:0]  tx_data = '0;
  logic [NP-1:0]     rx_ready;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [PW-1:0]     out_port;
  logic [SW-1:0]     out_stamp;
  logic [DW-1:0]     out_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [SW+DW-1:0] mq [NP][$];
  logic             hold_prev = 1'b0;
  logic [PW-1:0]    h_port;
  logic [SW-1:0]    h_stamp;
  logic [DW-1:0]    h_data;

  stamp_merger #(.NPORTS(NP), .DW(DW), .DEPTH(DEPTH), .SW(SW)) u_stamp_merger (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_ready(rx_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_port(out_port), .out_stamp(out_stamp), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int pick_port();
    int s = -1;
    for (int p = 0; p < NP; p++)
      if (mq[p].size() > 0)
        if (s < 0 || mq[p][0][SW+DW-1:DW] < mq[s][0][SW+DW-1:DW]) s = p;
    return s;
  endfunction

  function automatic bit stamp_tied(input int s);
    for (int p = 0; p < NP; p++)
      if (p != s && mq[p].size() > 0 && mq[p][0][SW+DW-1:DW] == mq[s][0][SW+DW-1:DW]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input int vprob, input int rprob);
    int s;
    logic [NP-1:0] acc;
    for (int p = 0; p < NP; p++) begin
      tx_valid[p] = ($urandom % 100) < vprob;
      tx_data[p*DW +: DW] = DW'($urandom);
    end
    out_ready = ($urandom % 100) < rprob;
    #1;
    for (int p = 0; p < NP; p++)
      chk("R3 rx_ready", 64'(rx_ready[p]), 64'(mq[p].size() < DEPTH));
    s = pick_port();
    chk("R8 out_valid", 64'(out_valid), 64'(s >= 0));
    if (s >= 0) begin
      chk(stamp_tied(s) ? "R6 tie port" : "R5 oldest port", 64'(out_port), 64'(s));
      chk("R2 stamp", 64'(out_stamp), 64'(mq[s][0][SW+DW-1:DW]));
      chk("R4 data", 64'(out_data), 64'(mq[s][0][DW-1:0]));
    end
    if (hold_prev) begin
      chk("R7 hold valid", 64'(out_valid), 64'(1));
      chk("R7 hold port", 64'(out_port), 64'(h_port));
      chk("R7 hold stamp", 64'(out_stamp), 64'(h_stamp));
      chk("R7 hold data", 64'(out_data), 64'(h_data));
    end
    hold_prev = out_valid && !out_ready;
    h_port = out_port; h_stamp = out_stamp; h_data = out_data;
    for (int p = 0; p < NP; p++) acc[p] = tx_valid[p] && (mq[p].size() < DEPTH);
    if (s >= 0 && out_ready) void'(mq[s].pop_front());
    for (int p = 0; p < NP; p++)
      if (acc[p]) mq[p].push_back({SW'(cyc), tx_data[p*DW +: DW]});
    @(negedge clk);
    cyc++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset out_valid", 64'(out_valid), 64'(0));
    chk("R1 reset rx_ready", 64'(rx_ready), 64'({NP{1'b1}}));
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    step(100, 0);
    #1;
    chk("R1 first stamp zero", 64'(out_stamp), 64'(0));
    chk("R6 first tie port", 64'(out_port), 64'(0));
    for (int i = 0; i < DEPTH + 2; i++) step(100, 0);
    for (int i = 0; i < NP * DEPTH + 2; i++) step(0, 100);
    for (int i = 0; i < 1200; i++) step(60, 70);
    for (int i = 0; i < 1200; i++) step(90, 20);
    for (int i = 0; i < 1200; i++) step(30, 95);
    for (int i = 0; i < 200; i++) step(100, 50);
    for (int i = 0; i < NP * DEPTH + 2; i++) step(0, 100);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule